// File: doc/BRIEF.md
# Parallel LMS Coefficient Adaptation Array

This block adapts every coefficient of an adaptive FIR filter in one step, following the least-mean-square recursion. Each tap has its own multiply-accumulate lane. A lane multiplies the current error sample by its reference sample and scales the product by a fixed power-of-two step size, applied as an arithmetic right shift. It adds the result to the tap's current coefficient and saturates the sum to the coefficient width. All lanes work at once, so a full set of new coefficients is ready in the same cycle.

The block writes the new coefficients back into its coefficient registers only on an explicit update command. A configuration command sets the array enable and the number of active taps. Taps outside the active range keep their value. The error sample comes from a one-entry error register that is loaded separately. A preload port writes single coefficients so that the filter can be seeded. A clear command returns the block to its reset state.

Top module: `lms_mac_array`

## Requirements
- R1: After a synchronous active-low reset, every coefficient is 0, the array is disabled, the active order is 0 and the error register is 0.
- R2: When `update` is high while the array is enabled, each tap i below the active order takes sat(w_i + ((e·x_i) >>> SHIFT)) at that edge. The coefficient, sample and error are signed two's complement. Tap i occupies bits [i*DW +: DW] of `x_window` and of `wt_out`. The new value is visible on `wt_out` one cycle later.
- R3: The step-size shift is arithmetic and rounds toward minus infinity. A product of -1 changes the coefficient by -1, and a product of +1 changes it by 0 (SHIFT=8).
- R4: A sum that falls outside the coefficient range is clamped to -2^(DW-1) or to 2^(DW-1)-1.
- R5: During an update, taps at index greater than or equal to the active order keep their value.
- R6: An update command while the array is disabled leaves every coefficient unchanged.
- R7: `cfg_valid` loads the enable and the order. An order above TAPS is stored as TAPS. An update in the same cycle as a configuration uses the previous configuration.
- R8: `err_load` captures `err_data` into the error register. An update in the same cycle as an error load uses the value held before that edge.
- R9: `clear` zeroes the coefficients and the error register, and disables the array with order 0. It overrides update, configuration, error load and preload in the same cycle.
- R10: `wt_wr` writes `wt_wr_data` into tap `wt_wr_idx` unless an update commits in the same cycle. In that case the preload is dropped.
- R11: With no update, preload or clear, all coefficients hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Clear command, returns to reset state |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_order | input | $clog2(TAPS+1) | Requested number of active taps |
| cfg_enable | input | 1 | Array enable loaded by the configuration |
| err_load | input | 1 | Load strobe for the error register |
| err_data | input | DW | Signed error sample |
| x_window | input | TAPS*DW | Reference samples, tap i at [i*DW +: DW] |
| update | input | 1 | Commit command for the computed coefficients |
| wt_wr | input | 1 | Single-coefficient preload strobe |
| wt_wr_idx | input | $clog2(TAPS) | Preload tap index |
| wt_wr_data | input | DW | Preload value |
| wt_out | output | TAPS*DW | Current coefficients, tap i at [i*DW +: DW] |

## Verification
Every command acts at the rising edge where it is sampled. Its effect on `wt_out` is due one cycle later, because the only register between the command and the output is the coefficient register. The bench applies each command at a falling edge and updates its arithmetic model at the next rising edge. It compares the whole coefficient vector at the falling edge after that, so each check falls half a cycle after the one register stage. Same-cycle collisions are checked in the cycle that follows the collision: configuration with update, error load with update, preload with commit, and clear with everything else. In each case the bench expects the previous state to govern the result.

// File: rtl/lms_mac_pkg.sv
// Shared types for the LMS coefficient adaptation array.
// Assumes: nothing beyond IEEE 1800-2017.
package lms_mac_pkg;

    // Source selected for each coefficient register in a cycle.
    typedef enum logic [1:0] {
        WSRC_HOLD   = 2'd0,
        WSRC_CLEAR  = 2'd1,
        WSRC_COMMIT = 2'd2,
        WSRC_LOAD   = 2'd3
    } wsrc_e;

endpackage

// File: rtl/lms_mac_lane.sv
// One adaptation lane: w + ((e * x) >>> SHIFT), saturated to DW bits.
// Purely combinational. Assumes SHIFT < 2*DW and signed two's complement data.
module lms_mac_lane #(
    parameter int DW    = 16,
    parameter int SHIFT = 8
) (
    input  logic signed [DW-1:0] w_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] e_i,
    output logic signed [DW-1:0] nxt_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] corr;
    logic signed [PW:0]   sum;
    logic                 fits;

    // Full-precision product of error and reference sample.
    assign prod = x_i * e_i;
    // Fixed step size: arithmetic shift, rounds toward minus infinity.
    assign corr = prod >>> SHIFT;
    // Sign-extended sum of old coefficient and correction.
    assign sum  = {{(DW + 1){w_i[DW-1]}}, w_i} + {corr[PW-1], corr};
    // The sum fits when all bits from the sign down to bit DW-1 agree.
    assign fits = (&sum[PW:DW-1]) | ~(|sum[PW:DW-1]);

    // Saturate to the coefficient range.
    always_comb begin
        if (fits) begin
            nxt_o = sum[DW-1:0];
        end else if (sum[PW]) begin
            nxt_o = {1'b1, {(DW - 1){1'b0}}};
        end else begin
            nxt_o = {1'b0, {(DW - 1){1'b1}}};
        end
    end
endmodule

// File: rtl/lms_mac_ctrl.sv
// Command decode: holds enable, active order and error sample, and picks
// the per-tap register source. Assumes single-cycle command strobes;
// clear beats everything; a commit blocks preload in the same cycle.
module lms_mac_ctrl
    import lms_mac_pkg::*;
#(
    parameter int  TAPS = 8,
    parameter int  DW   = 16,
    localparam int OW   = $clog2(TAPS + 1),
    localparam int IW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 cfg_valid_i,
    input  logic [OW-1:0]        cfg_order_i,
    input  logic                 cfg_enable_i,
    input  logic                 err_load_i,
    input  logic signed [DW-1:0] err_data_i,
    input  logic                 update_i,
    input  logic                 wt_wr_i,
    input  logic [IW-1:0]        wt_wr_idx_i,
    output logic                 en_q_o,
    output logic [OW-1:0]        ord_q_o,
    output logic signed [DW-1:0] err_q_o,
    output wsrc_e                src_o [TAPS]
);
    logic          commit;
    logic [OW-1:0] ord_clamped;

    // Orders beyond the lane count are held at the lane count.
    assign ord_clamped = (cfg_order_i > OW'(TAPS)) ? OW'(TAPS) : cfg_order_i;
    // A commit needs an update command on an enabled array.
    assign commit      = update_i & en_q_o & ~clear_i;

    // Configuration register: enable and active order.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            en_q_o  <= 1'b0;
            ord_q_o <= '0;
        end else if (cfg_valid_i) begin
            en_q_o  <= cfg_enable_i;
            ord_q_o <= ord_clamped;
        end
    end

    // One-entry error buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            err_q_o <= '0;
        end else if (err_load_i) begin
            err_q_o <= err_data_i;
        end
    end

    // Per-tap source selection.
    for (genvar i = 0; i < TAPS; i++) begin : g_src
        always_comb begin
            if (clear_i) begin
                src_o[i] = WSRC_CLEAR;
            end else if (commit) begin
                src_o[i] = (OW'(i) < ord_q_o) ? WSRC_COMMIT : WSRC_HOLD;
            end else if (wt_wr_i && (wt_wr_idx_i == IW'(i))) begin
                src_o[i] = WSRC_LOAD;
            end else begin
                src_o[i] = WSRC_HOLD;
            end
        end
    end
endmodule

// File: rtl/lms_weight_store.sv
// Coefficient registers, one per tap, written from the source chosen by
// the controller. Assumes the source array is already prioritised.
module lms_weight_store
    import lms_mac_pkg::*;
#(
    parameter int TAPS = 8,
    parameter int DW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wsrc_e                src_i  [TAPS],
    input  logic signed [DW-1:0] nxt_i  [TAPS],
    input  logic signed [DW-1:0] wr_data_i,
    output logic signed [DW-1:0] w_o    [TAPS]
);
    for (genvar i = 0; i < TAPS; i++) begin : g_reg
        // Coefficient register for tap i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_o[i] <= '0;
            end else begin
                case (src_i[i])
                    WSRC_CLEAR:  w_o[i] <= '0;
                    WSRC_COMMIT: w_o[i] <= nxt_i[i];
                    WSRC_LOAD:   w_o[i] <= wr_data_i;
                    default:     w_o[i] <= w_o[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/lms_mac_array.sv
// Top of the parallel LMS adaptation array: controller, TAPS lanes and the
// coefficient store. Assumes x_window is stable at the update edge.
module lms_mac_array
    import lms_mac_pkg::*;
#(
    parameter int  TAPS  = 8,
    parameter int  DW    = 16,
    parameter int  SHIFT = 8,
    localparam int OW    = $clog2(TAPS + 1),
    localparam int IW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 cfg_valid,
    input  logic [OW-1:0]        cfg_order,
    input  logic                 cfg_enable,
    input  logic                 err_load,
    input  logic [DW-1:0]        err_data,
    input  logic [TAPS*DW-1:0]   x_window,
    input  logic                 update,
    input  logic                 wt_wr,
    input  logic [IW-1:0]        wt_wr_idx,
    input  logic [DW-1:0]        wt_wr_data,
    output logic [TAPS*DW-1:0]   wt_out
);
    logic                 en_q;
    logic [OW-1:0]        ord_q;
    logic signed [DW-1:0] err_q;
    wsrc_e                src    [TAPS];
    logic signed [DW-1:0] x_lane [TAPS];
    logic signed [DW-1:0] w_cur  [TAPS];
    logic signed [DW-1:0] w_nxt  [TAPS];

    lms_mac_ctrl #(.TAPS(TAPS), .DW(DW)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .cfg_valid_i  (cfg_valid),
        .cfg_order_i  (cfg_order),
        .cfg_enable_i (cfg_enable),
        .err_load_i   (err_load),
        .err_data_i   (err_data),
        .update_i     (update),
        .wt_wr_i      (wt_wr),
        .wt_wr_idx_i  (wt_wr_idx),
        .en_q_o       (en_q),
        .ord_q_o      (ord_q),
        .err_q_o      (err_q),
        .src_o        (src)
    );

    for (genvar i = 0; i < TAPS; i++) begin : g_lane
        // Slice the reference window and expose the coefficients.
        assign x_lane[i]              = x_window[i*DW +: DW];
        assign wt_out[i*DW +: DW]     = w_cur[i];

        lms_mac_lane #(.DW(DW), .SHIFT(SHIFT)) lane_i (
            .w_i   (w_cur[i]),
            .x_i   (x_lane[i]),
            .e_i   (err_q),
            .nxt_o (w_nxt[i])
        );
    end

    lms_weight_store #(.TAPS(TAPS), .DW(DW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .nxt_i     (w_nxt),
        .wr_data_i (wt_wr_data),
        .w_o       (w_cur)
    );
endmodule

// File: rtl/lms_mac_array_chk.sv
// Assertion checker for lms_mac_array, attached with bind below.
module lms_mac_array_chk #(
    parameter int  TAPS = 8,
    parameter int  DW   = 16,
    localparam int OW   = $clog2(TAPS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear,
    input logic               update,
    input logic               wt_wr,
    input logic               en_q,
    input logic [OW-1:0]      ord_q,
    input logic [TAPS*DW-1:0] wt_out
);
    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wt_out == '0) && !en_q && (ord_q == '0));

    // R6
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !en_q && !wt_wr && !clear) |=> $stable(wt_out));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update && !wt_wr && !clear) |=> $stable(wt_out));

    // R7
    order_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ord_q <= OW'(TAPS));

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        // R5
        inactive_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (update && en_q && !clear && (OW'(i) >= ord_q))
            |=> $stable(wt_out[i*DW +: DW]));
    end
endmodule

bind lms_mac_array lms_mac_array_chk #(.TAPS(TAPS), .DW(DW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .update (update),
    .wt_wr  (wt_wr),
    .en_q   (en_q),
    .ord_q  (ord_q),
    .wt_out (wt_out)
);

// File: tb/lms_mac_array_tb_top.sv
// Self-checking bench for lms_mac_array with an arithmetic reference model.
module lms_mac_array_tb_top;
    localparam int TAPS  = 8;
    localparam int DW    = 16;
    localparam int SHIFT = 8;
    localparam int OW    = $clog2(TAPS + 1);
    localparam int IW    = $clog2(TAPS);
    localparam longint WMAX = 32767;
    localparam longint WMIN = -32768;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear = 1'b0;
    logic               cfg_valid = 1'b0;
    logic [OW-1:0]      cfg_order = '0;
    logic               cfg_enable = 1'b0;
    logic               err_load = 1'b0;
    logic [DW-1:0]      err_data = '0;
    logic [TAPS*DW-1:0] x_window = '0;
    logic               update = 1'b0;
    logic               wt_wr = 1'b0;
    logic [IW-1:0]      wt_wr_idx = '0;
    logic [DW-1:0]      wt_wr_data = '0;
    logic [TAPS*DW-1:0] wt_out;

    int errors = 0;
    int checks = 0;
    int unsigned seed = 32'h1234_5678;

    // Reference model state.
    longint wm [TAPS];
    bit     en_m = 0;
    int     ord_m = 0;
    longint err_m = 0;

    always #10 clk = ~clk;   // 50 MHz

    lms_mac_array #(.TAPS(TAPS), .DW(DW), .SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_valid(cfg_valid),
        .cfg_order(cfg_order), .cfg_enable(cfg_enable), .err_load(err_load),
        .err_data(err_data), .x_window(x_window), .update(update),
        .wt_wr(wt_wr), .wt_wr_idx(wt_wr_idx), .wt_wr_data(wt_wr_data),
        .wt_out(wt_out)
    );

    function automatic longint sx(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [DW-1:0] rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    // Advance the model at the rising edge, using pre-edge state.
    task automatic model_step();
        bit commit;
        if (!rst_n || clear) begin
            foreach (wm[i]) wm[i] = 0;
            en_m = 0; ord_m = 0; err_m = 0;
            return;
        end
        commit = update && en_m;
        if (commit) begin
            for (int i = 0; i < ord_m; i++) begin
                longint s;
                s = wm[i] + ((err_m * sx(x_window[i*DW +: DW])) >>> SHIFT);
                wm[i] = (s > WMAX) ? WMAX : (s < WMIN) ? WMIN : s;
            end
        end else if (wt_wr) begin
            wm[wt_wr_idx] = sx(wt_wr_data);
        end
        if (cfg_valid) begin
            en_m = cfg_enable;
            ord_m = (int'(cfg_order) > TAPS) ? TAPS : int'(cfg_order);
        end
        if (err_load) err_m = sx(err_data);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        clear = 0; cfg_valid = 0; err_load = 0; update = 0; wt_wr = 0;
    endtask

    task automatic check(input string req);
        logic [TAPS*DW-1:0] exp;
        foreach (wm[i]) exp[i*DW +: DW] = wm[i][DW-1:0];
        checks++;
        if (wt_out !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, wt_out, exp);
        end
    endtask

    task automatic cfg(input int ord, input bit en);
        cfg_valid = 1; cfg_order = OW'(ord); cfg_enable = en;
    endtask

    task automatic preload(input int idx, input longint v);
        wt_wr = 1; wt_wr_idx = IW'(idx); wt_wr_data = v[DW-1:0];
    endtask

    task automatic set_x_all(input longint v);
        for (int i = 0; i < TAPS; i++) x_window[i*DW +: DW] = v[DW-1:0];
    endtask

    task automatic set_x_rand();
        for (int i = 0; i < TAPS; i++) x_window[i*DW +: DW] = rnd16();
    endtask

    task automatic load_err(input longint v);
        err_load = 1; err_data = v[DW-1:0];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        foreach (wm[i]) wm[i] = 0;
        // R1: reset state; an update after reset finds the array disabled.
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        check("R1");
        set_x_all(1000); update = 1; tick();
        check("R1");

        // R10: seed every tap through the preload port.
        for (int i = 0; i < TAPS; i++) begin
            preload(i, 100 * i - 300); tick();
        end
        check("R10");

        // R2: full order, sweep of random samples and errors.
        cfg(TAPS, 1); tick();
        for (int k = 0; k < 60; k++) begin
            load_err(sx(rnd16())); tick();
            set_x_rand(); update = 1; tick();
            check("R2");
        end

        // R3: floor rounding of the shift.
        for (int i = 0; i < TAPS; i++) begin preload(i, 10); tick(); end
        load_err(-1); set_x_all(1); tick();
        update = 1; tick(); check("R3");
        load_err(1); tick();
        update = 1; tick(); check("R3");
        load_err(-3); set_x_all(100); tick();
        update = 1; tick(); check("R3");

        // R4: saturation at both ends.
        for (int i = 0; i < TAPS; i++) begin preload(i, (i % 2) ? -32000 : 32000); tick(); end
        load_err(32767); tick();
        for (int i = 0; i < TAPS; i++)
            x_window[i*DW +: DW] = (i % 2) ? 16'h8000 : 16'h7fff;
        update = 1; tick(); check("R4");
        update = 1; tick(); check("R4");

        // R5: every order from 0 to TAPS.
        load_err(2000);
        for (int o = 0; o <= TAPS; o++) begin
            for (int i = 0; i < TAPS; i++) begin preload(i, 0); tick(); end
            cfg(o, 1); tick();
            set_x_all(512); update = 1; tick();
            check("R5");
        end

        // R7: order beyond TAPS is clamped; same-cycle config uses old values.
        for (int i = 0; i < TAPS; i++) begin preload(i, 5); tick(); end
        cfg(12, 1); tick();
        set_x_rand(); update = 1; tick(); check("R7");
        cfg(2, 1); set_x_rand(); update = 1; tick(); check("R7");
        set_x_rand(); update = 1; tick(); check("R7");
        cfg(TAPS, 0); update = 1; tick(); check("R7");

        // R6: disabled array ignores update.
        load_err(-700); tick();
        set_x_rand(); update = 1; tick(); check("R6");
        update = 1; tick(); check("R6");

        // R8: error load and update in the same cycle.
        cfg(TAPS, 1); load_err(256); tick();
        set_x_all(256); load_err(-5000); update = 1; tick(); check("R8");
        update = 1; tick(); check("R8");

        // R10: preload dropped during a commit, accepted when disabled.
        preload(3, 1234); update = 1; set_x_rand(); tick(); check("R10");
        cfg(TAPS, 0); tick();
        preload(3, 1234); update = 1; tick(); check("R10");

        // R11: idle cycles hold.
        cfg(TAPS, 1); tick();
        set_x_rand(); load_err(999); tick();
        repeat (5) tick();
        check("R11");

        // R9: clear beats update, config, error load and preload.
        clear = 1; update = 1; cfg(TAPS, 1); load_err(3000); preload(1, 77); tick();
        check("R9");
        preload(2, 40); tick();
        set_x_all(3000); update = 1; tick();
        check("R9");
        cfg(TAPS, 1); tick();
        update = 1; tick();
        check("R9");

        finish_run();
    end
endmodule